// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block places incoming frames into a circular receive area of a local packet memory. The memory is cut into 256-byte pages: address bits [15:8] name the page and bits [7:0] the byte within it. The ring spans the pages from a programmed first page up to, but not including, a programmed limit page. Each frame's payload goes in first, starting four bytes into the current page. Once the last byte is in, a four-byte header goes into those reserved bytes and the current-page pointer moves on.

The host drains the ring and tells the block how far it has read by moving a boundary page. A frame that would write into the boundary page is abandoned. This raises a sticky overwrite flag and a ring-reset flag. A monitor mode checks frames but stores nothing.

Frame bytes arrive on a valid/ready stream. A byte is taken on every clock where `in_valid` and `in_ready` are both high. `in_ready` is low only while a header is being written. The sender must hold its byte and markers stable until the byte is taken. The error inputs are sampled together with the byte marked last. The memory port is a plain write strobe that cannot stall.

Top module: `rxring_mgr`

## Requirements
- R1: `in_ready` is high except for exactly four consecutive cycles. Those cycles start on the cycle after the accepted last byte of a committed frame. In each of them the block writes one header byte.
- R2: The first byte of a frame (`in_first`) is written at offset 4 of the current page. Each later byte goes to the next address. Each write happens in the same cycle the byte is accepted.
- R3: After offset 255 of a page, writing continues at offset 0 of the next page. If that next page equals the limit page, writing continues at the first page instead.
- R4: Header layout within the current page: offset 0 holds the status byte, offset 1 the next-frame page, offset 2 the low byte and offset 3 the high byte of the count. The count is the frame length plus 4.
- R5: The next-frame page is the page after the one holding the frame's last byte, with the R3 wrap applied.
- R6: Status byte bit positions:
  - bit0: frame good and stored.
  - bit1: `in_crc_err`.
  - bit2: `in_align_err`.
  - bit4: missed.

  All other bits are 0. The status byte of every completed frame is readable at register 6.
- R7: The current page takes the next-frame value only after the fourth header byte. This happens only for error-free frames, or for errored frames when config bit0 (keep errored) is set. Otherwise nothing is committed and the current page is unchanged.
- R8: A byte that would land in the boundary page is not written, and neither is any later byte of that frame. The overwrite flag (register 5 bit0) is set. The frame ends with the missed bit set, no header and no change to the current page.
- R9: With config bit1 (monitor) set, no frame byte or header is written. Each frame's status has the missed bit set.
- R10: The ring-reset flag (register 5 bit1) is set together with the overwrite flag. It is cleared by a host write to the boundary register with a value different from the stored one. Writing 1 to register 5 bit0 clears only the overwrite flag.
- R11: Register map, with reset values:

  | Address | Register | Reset value | Access |
  |---|---|---|---|
  | 0 | first page | 0x40 | read/write |
  | 1 | limit page | 0x60 | read/write |
  | 2 | boundary | 0x40 | read/write |
  | 3 | current page | 0x41 | read/write |
  | 4 | config | 0 | read/write |
  | 5 | flags | 0 | read, write-1-to-clear bit0 |
  | 6 | last status | 0 | read-only |
  | 7 | (unused) | reads 0 | — |

  Writes take effect at the clock edge. Reads are combinational.
- R12: Bytes offered outside a frame are accepted and discarded without any memory write. A frame is open from an `in_first` byte to its `in_last` byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Frame byte |
| in_first | input | 1 | Byte opens a frame |
| in_last | input | 1 | Byte closes a frame |
| in_crc_err | input | 1 | Checksum error, sampled with last byte |
| in_align_err | input | 1 | Alignment error, sampled with last byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address (page, offset) |
| mem_wdata | output | 8 | Memory write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
Most internal faults show up at the memory port within the same cycle. A wrong write pointer, a missed wrap, or a mishandled boundary comparison each put `mem_addr` or `mem_we` wrong on the very byte concerned. A wrong frame length or next-page value appears in the four header cycles straight after the last byte. A wrong commit decision shows either as an unexpected stall on `in_ready`, or one frame later, when the next frame's first byte lands on the wrong page. Flag faults are only visible through register reads, so the reads follow each overwrite, clear and boundary move.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int BYTE_W    = 8;
  localparam int LEN_W     = 2 * BYTE_W;
  localparam int HDR_BYTES = 4;
  localparam int HC_W      = $clog2(HDR_BYTES);

  // status byte bit positions (decoded by the host)
  localparam int STB_OK    = 0;
  localparam int STB_CRC   = 1;
  localparam int STB_ALIGN = 2;
  localparam int STB_MISS  = 4;

  // register indices
  localparam logic [2:0] RG_FIRST = 3'd0;
  localparam logic [2:0] RG_LIMIT = 3'd1;
  localparam logic [2:0] RG_BND   = 3'd2;
  localparam logic [2:0] RG_CUR   = 3'd3;
  localparam logic [2:0] RG_CFG   = 3'd4;
  localparam logic [2:0] RG_FLAG  = 3'd5;
  localparam logic [2:0] RG_STAT  = 3'd6;

  typedef enum logic {ST_BODY, ST_HDR} rx_state_e;
endpackage

// File: rtl/rxring_pgstep.sv
module rxring_pgstep
  import rxring_pkg::*;
(
  input  logic [BYTE_W-1:0] first_pg,
  input  logic [BYTE_W-1:0] limit_pg,
  input  logic [BYTE_W-1:0] pg_in,
  output logic [BYTE_W-1:0] pg_out
);
  logic [BYTE_W-1:0] inc;
  always_comb begin
    inc    = pg_in + 1'b1;
    pg_out = (inc == limit_pg) ? first_pg : inc;
  end
endmodule

// File: rtl/rxring_regs.sv
module rxring_regs
  import rxring_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FIRST_RST = 8'h40,
  parameter logic [BYTE_W-1:0] LIMIT_RST = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              cur_load,
  input  logic [BYTE_W-1:0] cur_next,
  input  logic              ovw_evt,
  input  logic              stat_we,
  input  logic [BYTE_W-1:0] stat_val,
  output logic [BYTE_W-1:0] first_pg,
  output logic [BYTE_W-1:0] limit_pg,
  output logic [BYTE_W-1:0] bnd_pg,
  output logic [BYTE_W-1:0] cur_pg,
  output logic              keep_err,
  output logic              mon_en,
  output logic              ovw_flag,
  output logic              rst_flag
);
  localparam logic [BYTE_W-1:0] CUR_RST = FIRST_RST + 1'b1;
  logic [BYTE_W-1:0] stat_q;
  logic wr_first, wr_limit, wr_bnd, wr_cur, wr_cfg, wr_flag;

  always_comb begin
    wr_first = reg_we && reg_addr == RG_FIRST;
    wr_limit = reg_we && reg_addr == RG_LIMIT;
    wr_bnd   = reg_we && reg_addr == RG_BND;
    wr_cur   = reg_we && reg_addr == RG_CUR;
    wr_cfg   = reg_we && reg_addr == RG_CFG;
    wr_flag  = reg_we && reg_addr == RG_FLAG;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_pg <= FIRST_RST;
      limit_pg <= LIMIT_RST;
      bnd_pg   <= FIRST_RST;
      cur_pg   <= CUR_RST;
      keep_err <= 1'b0;
      mon_en   <= 1'b0;
      ovw_flag <= 1'b0;
      rst_flag <= 1'b0;
      stat_q   <= '0;
    end else begin
      if (wr_first) first_pg <= reg_wdata;
      if (wr_limit) limit_pg <= reg_wdata;
      if (wr_bnd)   bnd_pg   <= reg_wdata;
      if (cur_load)    cur_pg <= cur_next;
      else if (wr_cur) cur_pg <= reg_wdata;
      if (wr_cfg) begin
        keep_err <= reg_wdata[0];
        mon_en   <= reg_wdata[1];
      end
      if (ovw_evt)                     ovw_flag <= 1'b1;
      else if (wr_flag && reg_wdata[0]) ovw_flag <= 1'b0;
      if (ovw_evt)                          rst_flag <= 1'b1;
      else if (wr_bnd && reg_wdata != bnd_pg) rst_flag <= 1'b0;
      if (stat_we) stat_q <= stat_val;
    end
  end

  always_comb begin
    case (reg_addr)
      RG_FIRST: reg_rdata = first_pg;
      RG_LIMIT: reg_rdata = limit_pg;
      RG_BND:   reg_rdata = bnd_pg;
      RG_CUR:   reg_rdata = cur_pg;
      RG_CFG:   reg_rdata = {6'd0, mon_en, keep_err};
      RG_FLAG:  reg_rdata = {6'd0, rst_flag, ovw_flag};
      RG_STAT:  reg_rdata = stat_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BYTE_W-1:0]       in_data,
  input  logic                    in_first,
  input  logic                    in_last,
  input  logic                    in_crc_err,
  input  logic                    in_align_err,
  input  logic [BYTE_W-1:0]       first_pg,
  input  logic [BYTE_W-1:0]       limit_pg,
  input  logic [BYTE_W-1:0]       bnd_pg,
  input  logic [BYTE_W-1:0]       cur_pg,
  input  logic                    keep_err,
  input  logic                    mon_en,
  output logic                    mem_we,
  output logic [BYTE_W+OFF_W-1:0] mem_addr,
  output logic [BYTE_W-1:0]       mem_wdata,
  output logic                    cur_load,
  output logic [BYTE_W-1:0]       cur_next,
  output logic                    ovw_evt,
  output logic                    stat_we,
  output logic [BYTE_W-1:0]       stat_val
);
  localparam int AW = BYTE_W + OFF_W;
  localparam logic [OFF_W-1:0] OFF_MAX = '1;
  localparam logic [HC_W-1:0]  HC_LAST = HC_W'(HDR_BYTES - 1);

  rx_state_e         state_q;
  logic              open_q, drop_q;
  logic [AW-1:0]     wptr_q;
  logic [LEN_W-1:0]  len_q, hlen_q;
  logic [HC_W-1:0]   hcnt_q;
  logic [BYTE_W-1:0] hstat_q, hnext_q;

  logic [AW-1:0]     byte_addr, next_addr;
  logic [BYTE_W-1:0] byte_pg, pg_nx;
  logic [LEN_W-1:0]  len_now;
  logic acc, drop_cur, hit_bnd, ovw_now, wr_pay, frame_ovw, good, commit;

  rxring_pgstep u_step (.first_pg(first_pg), .limit_pg(limit_pg), .pg_in(byte_pg), .pg_out(pg_nx));

  always_comb begin
    in_ready  = (state_q == ST_BODY);
    byte_addr = in_first ? {cur_pg, OFF_W'(HDR_BYTES)} : wptr_q;
    byte_pg   = byte_addr[AW-1:OFF_W];
    next_addr = (byte_addr[OFF_W-1:0] == OFF_MAX) ? {pg_nx, {OFF_W{1'b0}}} : byte_addr + 1'b1;
    acc       = in_valid && in_ready && (in_first || open_q);
    drop_cur  = in_first ? 1'b0 : drop_q;
    hit_bnd   = (byte_pg == bnd_pg);
    ovw_now   = acc && !mon_en && !drop_cur && hit_bnd;
    wr_pay    = acc && !mon_en && !drop_cur && !hit_bnd;
    frame_ovw = drop_cur || ovw_now;
    len_now   = (in_first ? '0 : len_q) + 1'b1;
    good      = !in_crc_err && !in_align_err;
    commit    = acc && in_last && !mon_en && !frame_ovw && (good || keep_err);
    stat_val  = '0;
    stat_val[STB_MISS]  = mon_en || frame_ovw;
    stat_val[STB_OK]    = good && !(mon_en || frame_ovw);
    stat_val[STB_CRC]   = in_crc_err;
    stat_val[STB_ALIGN] = in_align_err;
    stat_we   = acc && in_last;
    ovw_evt   = ovw_now;
    cur_load  = (state_q == ST_HDR) && (hcnt_q == HC_LAST);
    cur_next  = hnext_q;
  end

  always_comb begin
    if (state_q == ST_HDR) begin
      mem_we   = 1'b1;
      mem_addr = {cur_pg, OFF_W'(hcnt_q)};
      case (hcnt_q)
        2'd0:    mem_wdata = hstat_q;
        2'd1:    mem_wdata = hnext_q;
        2'd2:    mem_wdata = hlen_q[BYTE_W-1:0];
        default: mem_wdata = hlen_q[LEN_W-1:BYTE_W];
      endcase
    end else begin
      mem_we    = wr_pay;
      mem_addr  = byte_addr;
      mem_wdata = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_BODY;
      open_q  <= 1'b0;
      drop_q  <= 1'b0;
      wptr_q  <= '0;
      len_q   <= '0;
      hcnt_q  <= '0;
      hstat_q <= '0;
      hnext_q <= '0;
      hlen_q  <= '0;
    end else if (state_q == ST_HDR) begin
      hcnt_q <= hcnt_q + 1'b1;
      if (hcnt_q == HC_LAST) state_q <= ST_BODY;
    end else if (acc) begin
      wptr_q <= next_addr;
      len_q  <= len_now;
      drop_q <= frame_ovw;
      open_q <= !in_last;
      if (commit) begin
        state_q <= ST_HDR;
        hcnt_q  <= '0;
        hstat_q <= stat_val;
        hnext_q <= pg_nx;
        hlen_q  <= len_now + LEN_W'(HDR_BYTES);
      end
    end
  end
endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr
  import rxring_pkg::*;
#(
  parameter int                OFF_W     = 8,
  parameter logic [BYTE_W-1:0] FIRST_RST = 8'h40,
  parameter logic [BYTE_W-1:0] LIMIT_RST = 8'h60
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BYTE_W-1:0]       in_data,
  input  logic                    in_first,
  input  logic                    in_last,
  input  logic                    in_crc_err,
  input  logic                    in_align_err,
  output logic                    mem_we,
  output logic [BYTE_W+OFF_W-1:0] mem_addr,
  output logic [BYTE_W-1:0]       mem_wdata,
  input  logic                    reg_we,
  input  logic [2:0]              reg_addr,
  input  logic [BYTE_W-1:0]       reg_wdata,
  output logic [BYTE_W-1:0]       reg_rdata
);
  logic [BYTE_W-1:0] first_pg, limit_pg, bnd_pg, cur_pg, cur_next, stat_val;
  logic keep_err, mon_en, ovw_flag, rst_flag, cur_load, ovw_evt, stat_we;

  rxring_regs #(.FIRST_RST(FIRST_RST), .LIMIT_RST(LIMIT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_load(cur_load),
    .cur_next(cur_next), .ovw_evt(ovw_evt), .stat_we(stat_we), .stat_val(stat_val),
    .first_pg(first_pg), .limit_pg(limit_pg), .bnd_pg(bnd_pg), .cur_pg(cur_pg),
    .keep_err(keep_err), .mon_en(mon_en), .ovw_flag(ovw_flag), .rst_flag(rst_flag)
  );

  rxring_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .in_crc_err(in_crc_err), .in_align_err(in_align_err),
    .first_pg(first_pg), .limit_pg(limit_pg), .bnd_pg(bnd_pg), .cur_pg(cur_pg),
    .keep_err(keep_err), .mon_en(mon_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cur_load(cur_load), .cur_next(cur_next),
    .ovw_evt(ovw_evt), .stat_we(stat_we), .stat_val(stat_val)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int OFF_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                mem_we,
  input logic [8+OFF_W-1:0]  mem_addr,
  input logic                reg_we,
  input logic [7:0]          first_pg,
  input logic [7:0]          limit_pg,
  input logic [7:0]          bnd_pg,
  input logic [7:0]          cur_pg,
  input logic                ovw_flag,
  input logic                rst_flag
);
  logic [7:0] wpg;
  assign wpg = mem_addr[8+OFF_W-1:OFF_W];

  a_r1_hdr_four: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |=> !in_ready ##1 !in_ready ##1 !in_ready ##1 in_ready);

  a_r1_stall_writes: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> mem_we);

  a_r4_hdr_order: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && mem_addr[OFF_W-1:0] == '0) |=> (mem_addr[OFF_W-1:0] == OFF_W'(1)));

  a_r8_no_bnd_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && in_ready) |-> (wpg != bnd_pg));

  a_r3_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && first_pg < limit_pg) |-> (wpg >= first_pg && wpg < limit_pg));

  a_r10_rst_with_ovw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovw_flag) |-> rst_flag);

  a_r7_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_ready) && !$past(reg_we)) |-> $stable(cur_pg));
endmodule

bind rxring_mgr rxring_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .reg_we(reg_we), .first_pg(first_pg),
  .limit_pg(limit_pg), .bnd_pg(bnd_pg), .cur_pg(cur_pg),
  .ovw_flag(ovw_flag), .rst_flag(rst_flag)
);

// File: tb/tb_rxring_mgr.sv
module tb_rxring_mgr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_first = 0, in_last = 0, in_crc_err = 0, in_align_err = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, reg_rdata;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;

  int tests = 0, fails = 0, cycles = 0;

  // behavioural reference state
  int m_first = 'h40, m_limit = 'h60, m_bnd = 'h40, m_cur = 'h41;
  int m_keep = 0, m_mon = 0, m_ovw = 0, m_rst = 0, m_stat = 0;
  int m_open = 0, m_drop = 0, m_wp = 0, m_len = 0, m_hnext = 0;
  int hq[$];

  rxring_mgr dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .in_crc_err(in_crc_err), .in_align_err(in_align_err),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R1 watchdog: actual still running, expected finished");
      summary();
      $finish;
    end
  end

  function automatic int step_pg(int p);
    int n = (p + 1) & 255;
    return (n == m_limit) ? m_first : n;
  endfunction

  // one clock: compare outputs against the model at negedge, update the model after posedge
  task automatic cyc();
    bit erdy, ewe, acc, hit, dr, mon, f, l, crc, fae;
    int ea = 0, ed = 0, a = 0;
    @(negedge clk);
    erdy = (hq.size() == 0);
    ewe = 0; acc = 0; hit = 0; dr = 0;
    mon = (m_mon != 0); f = in_first; l = in_last; crc = in_crc_err; fae = in_align_err;
    if (!erdy) begin
      ewe = 1; ea = hq[0] >> 8; ed = hq[0] & 255;
    end else if (in_valid && (in_first || m_open != 0)) begin
      acc = 1;
      a   = f ? (m_cur * 256 + 4) : m_wp;
      dr  = f ? 0 : (m_drop != 0);
      hit = ((a >> 8) == m_bnd);
      if (!mon && !dr && !hit) begin ewe = 1; ea = a; ed = in_data; end
    end
    tests++;
    if (in_ready !== erdy || mem_we !== ewe ||
        (ewe && (mem_addr !== 16'(ea) || mem_wdata !== 8'(ed)))) begin
      fails++;
      $display("FAIL R1/R2/R3/R4/R5 cycle %0d: actual rdy=%0b we=%0b a=%h d=%h expected rdy=%0b we=%0b a=%h d=%h",
               cycles, in_ready, mem_we, mem_addr, mem_wdata, erdy, ewe, 16'(ea), 8'(ed));
    end
    @(posedge clk);
    #1;
    if (reg_we) begin
      case (reg_addr)
        3'd0: m_first = reg_wdata;
        3'd1: m_limit = reg_wdata;
        3'd2: begin if (reg_wdata != m_bnd) m_rst = 0; m_bnd = reg_wdata; end
        3'd3: m_cur = reg_wdata;
        3'd4: begin m_keep = reg_wdata[0]; m_mon = reg_wdata[1]; end
        3'd5: if (reg_wdata[0]) m_ovw = 0;
        default: ;
      endcase
    end
    if (!erdy) begin
      void'(hq.pop_front());
      if (hq.size() == 0) m_cur = m_hnext;
    end else if (acc) begin
      bit ovn, dr2, good, miss;
      int len, pg, nx, stat, cnt;
      ovn = !mon && !dr && hit;
      if (ovn) begin m_ovw = 1; m_rst = 1; end
      dr2 = dr || ovn;
      len = (f ? 0 : m_len) + 1;
      pg  = a >> 8;
      nx  = step_pg(pg);
      if (l) begin
        good = !crc && !fae;
        miss = mon || dr2;
        stat = ((good && !miss) ? 1 : 0) | (crc ? 2 : 0) | (fae ? 4 : 0) | (miss ? 16 : 0);
        m_stat = stat;
        if (!mon && !dr2 && (good || m_keep != 0)) begin
          cnt = len + 4;
          hq.push_back((m_cur * 256 + 0) * 256 + stat);
          hq.push_back((m_cur * 256 + 1) * 256 + nx);
          hq.push_back((m_cur * 256 + 2) * 256 + (cnt & 255));
          hq.push_back((m_cur * 256 + 3) * 256 + ((cnt >> 8) & 255));
          m_hnext = nx;
        end
        m_open = 0;
      end else begin
        m_open = 1;
        m_len  = len;
        m_drop = dr2;
        m_wp   = ((a & 255) == 255) ? nx * 256 : a + 1;
      end
    end
  endtask

  task automatic idle(int n);
    in_valid = 0; in_first = 0; in_last = 0;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic send_frame(int n, bit crc, bit fae, int seed);
    for (int i = 0; i < n; i++) begin
      bit taken;
      if (i % 7 == 6) begin in_valid = 0; cyc(); end
      in_valid = 1; in_data = 8'(seed + i * 3);
      in_first = (i == 0); in_last = (i == n - 1);
      in_crc_err = crc; in_align_err = fae;
      do begin taken = (hq.size() == 0); cyc(); end while (!taken);
    end
    in_crc_err = 0; in_align_err = 0;
    idle(6);
  endtask

  task automatic reg_wr(logic [2:0] ad, logic [7:0] v);
    reg_we = 1; reg_addr = ad; reg_wdata = v;
    cyc();
    reg_we = 0;
  endtask

  task automatic reg_chk(logic [2:0] ad, logic [7:0] exp, string tag);
    reg_addr = ad;
    #1;
    tests++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s reg %0d: actual %h expected %h", tag, ad, reg_rdata, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset values
    reg_chk(0, 8'h40, "R11"); reg_chk(1, 8'h60, "R11"); reg_chk(2, 8'h40, "R11");
    reg_chk(3, 8'h41, "R11"); reg_chk(4, 8'h00, "R11"); reg_chk(5, 8'h00, "R11");
    reg_chk(6, 8'h00, "R11"); reg_chk(7, 8'h00, "R11");
    reg_wr(1, 8'h44);                       // ring = pages 40..43
    reg_chk(1, 8'h44, "R11");
    // R2 R4 R5: short good frame at page 41
    send_frame(10, 0, 0, 1);
    reg_chk(3, 8'h42, "R7"); reg_chk(6, 8'h01, "R6");
    // R8: 600-byte frame from page 42 reaches boundary page 40 after wrap
    send_frame(600, 0, 0, 5);
    reg_chk(5, 8'h03, "R8"); reg_chk(3, 8'h42, "R8"); reg_chk(6, 8'h10, "R8");
    // R10 flag clearing
    reg_wr(5, 8'h01);
    reg_chk(5, 8'h02, "R10");
    reg_wr(2, 8'h40);
    reg_chk(5, 8'h02, "R10");
    reg_wr(2, 8'h41);
    reg_chk(5, 8'h00, "R10");
    // R3 R5: 520 bytes from 42 wrap into 40, next page 41, count 0x20C
    send_frame(520, 0, 0, 9);
    reg_chk(3, 8'h41, "R3"); reg_chk(6, 8'h01, "R5");
    reg_wr(2, 8'h40);
    // R7: checksum-errored frame dropped without keep
    send_frame(20, 1, 0, 2);
    reg_chk(3, 8'h41, "R7"); reg_chk(6, 8'h02, "R6");
    // R7: keep errored, alignment error frame committed
    reg_wr(4, 8'h01);
    send_frame(5, 0, 1, 3);
    reg_chk(3, 8'h42, "R7"); reg_chk(6, 8'h04, "R6");
    // R9: monitor mode
    reg_wr(4, 8'h02);
    send_frame(8, 0, 0, 4);
    reg_chk(6, 8'h10, "R9"); reg_chk(3, 8'h42, "R9"); reg_chk(5, 8'h00, "R9");
    reg_wr(4, 8'h00);
    // R12: stray bytes outside a frame
    in_valid = 1; in_first = 0; in_last = 0; in_data = 8'hAA;
    for (int i = 0; i < 3; i++) cyc();
    idle(1);
    reg_chk(3, 8'h42, "R12");
    // R2 R5: single-byte frame
    send_frame(1, 0, 0, 7);
    reg_chk(3, 8'h43, "R5"); reg_chk(6, 8'h01, "R2");
    summary();
    $finish;
  end
endmodule